// File: doc/BRIEF.md
# Receive Character Queue with Per-Byte Error Tags

This block buffers received serial characters between a line receiver and a CPU-facing register interface. Each stored slot keeps an 8-bit character together with three error tags (parity mismatch, bad stop bit, line break), so that the tags belonging to a byte are only presented while that byte is at the front of the queue. Around the storage it produces the status the register side needs: a not-empty flag, a threshold flag selected by a 2-bit code, a sticky overrun flag, a sticky "some stored byte was bad" summary, and an idle timeout measured in ticks of a 16x-oversampling enable.

The receiver side is a valid/ready stream that cannot be stalled: `in_ready` only reports whether there is room, and a character offered while the queue is full is dropped and recorded as overrun. The CPU side is a valid/ready stream as well: `out_valid` is high while a byte is held, and a byte leaves on a cycle with `out_valid` and `out_ready` both high. A status-read strobe, a flush command, the threshold code and the current frame length in bits are plain control inputs.

Top module: `rx_err_queue`

## Requirements
- R1: The queue holds up to DEPTH (16) entries in arrival order; a character is stored when `in_valid` is high, the queue is not full and `clr` is low, and `out_data` shows the oldest stored byte while `count` reports the number of stored entries.
- R2: `trig_hit` is high exactly while `count` is at least the level selected by `trig_sel`: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects DEPTH-2 (14).
- R3: `data_ready` is high exactly while at least one entry is stored; it rises only after a character was accepted.
- R4: `in_valid` while the queue is full (and `clr` low) discards that character and sets the sticky `overrun` flag on the next cycle; `lsr_rd` clears it, a new overrun in the same cycle wins.
- R5: `head_flags` bit 0 parity, bit 1 framing, bit 2 break, shows the tags of the head entry; it is zero while empty, and after an `lsr_rd` it reads zero until the head entry changes.
- R6: `err_any` sets when an entry with any tag bit set is stored and stays set until an `lsr_rd` in a cycle after which no tagged entry remains stored.
- R7: `timeout` rises once, with at least one entry stored and neither `in_valid` nor a pop occurring, `tick16` has been high in 64*`frame_bits` cycles counted from the last restart.
- R8: A pop clears a pending timeout and restarts the count; while no timeout is pending, `in_valid` or a pop restarts the count, while a pending timeout ignores `in_valid`.
- R9: `clr` empties the queue (count zero), clears `timeout`, `err_any` and the status-read mask, and leaves `overrun` unchanged; push and pop are ignored in that cycle.
- R10: A push and a pop in the same cycle on a queue that is neither empty nor full both take effect and leave `count` unchanged.
- R11: A pop request on an empty queue has no effect: `count` stays zero and `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Flush the queue |
| trig_sel | input | 2 | Threshold code |
| frame_bits | input | 4 | Bits per serial frame, sets the timeout window |
| tick16 | input | 1 | 16x receive clock enable |
| in_valid | input | 1 | Received character offered |
| in_data | input | 8 | Received character |
| in_flags | input | 3 | Tags of the received character: bit 0 parity, 1 framing, 2 break |
| in_ready | output | 1 | Room for another character (advisory) |
| out_valid | output | 1 | A byte is held |
| out_ready | input | 1 | CPU takes the head byte |
| out_data | output | 8 | Head byte, zero when empty |
| head_flags | output | 3 | Tags of the head byte as in R5 |
| lsr_rd | input | 1 | CPU reads line status |
| data_ready | output | 1 | Queue not empty |
| trig_hit | output | 1 | Count at or above threshold |
| overrun | output | 1 | Sticky overrun |
| err_any | output | 1 | Sticky tagged-byte summary |
| timeout | output | 1 | Idle timeout pending |
| count | output | 5 | Number of stored entries |

## Verification
The bench builds the block with its defaults, DEPTH 16 and an 8-bit character, so the 14-entry threshold and the full-queue overrun path are reached within a few dozen pushes. It drives `frame_bits` at 2 for most of the run, which shrinks the idle window to 128 ticks and lets random traffic cross the timeout boundary many times, and runs one directed window at 10 bits (640 ticks) to cover a realistic frame length.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rxq_tags_t;

  // threshold in entries for a 2-bit selection code
  function automatic int sel_level(input logic [1:0] code, input int depth);
    int lv;
    case (code)
      2'd0:    lv = 1;
      2'd1:    lv = 4;
      2'd2:    lv = 8;
      default: lv = depth - 2;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  rxq_pkg::rxq_tags_t wr_tags,
  input  logic              rd_en,
  output logic [DATA_W-1:0] head_data,
  output rxq_pkg::rxq_tags_t head_tags,
  output logic [CW-1:0]     fill
);
  logic [DATA_W-1:0]  data_mem [DEPTH];
  rxq_pkg::rxq_tags_t tag_mem  [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      data_mem[wp] <= wr_data;
      tag_mem[wp]  <= wr_tags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else if (flush) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr_en) wp <= bump(wp);
      if (rd_en) rp <= bump(rp);
      case ({wr_en, rd_en})
        2'b10:   fill <= fill + CW'(1);
        2'b01:   fill <= fill - CW'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign head_data = data_mem[rp];
  assign head_tags = tag_mem[rp];
endmodule

// File: rtl/rxq_errtrack.sv
module rxq_errtrack #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic wr_en,
  input  logic wr_bad,
  input  logic rd_en,
  input  logic rd_bad,
  input  logic lsr_rd,
  input  logic empty,
  output logic summary,
  output logic mask
);
  logic [CW-1:0] bad_cnt, bad_nxt;

  always_comb begin
    bad_nxt = bad_cnt;
    if (wr_en && wr_bad) bad_nxt = bad_nxt + CW'(1);
    if (rd_en && rd_bad) bad_nxt = bad_nxt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_cnt <= '0;
      summary <= 1'b0;
      mask    <= 1'b0;
    end else if (flush) begin
      bad_cnt <= '0;
      summary <= 1'b0;
      mask    <= 1'b0;
    end else begin
      bad_cnt <= bad_nxt;
      if (wr_en && wr_bad)               summary <= 1'b1;
      else if (lsr_rd && bad_nxt == '0) summary <= 1'b0;
      if (rd_en || empty)  mask <= 1'b0;
      else if (lsr_rd)     mask <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int FRAME_W = 4,
  localparam int TW = FRAME_W + 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               tick,
  input  logic               busy,
  input  logic               arrive,
  input  logic               take,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               fired
);
  logic [TW-1:0] tmr;
  logic [TW-1:0] lim;

  // four character times of 16 ticks per bit
  assign lim = {frame_bits, 6'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr   <= '0;
      fired <= 1'b0;
    end else if (flush || take) begin
      tmr   <= '0;
      fired <= 1'b0;
    end else if (fired) begin
      tmr <= tmr;
    end else if (arrive || !busy) begin
      tmr <= '0;
    end else if (tick) begin
      if (tmr == lim - TW'(1)) begin
        fired <= 1'b1;
        tmr   <= '0;
      end else begin
        tmr <= tmr + TW'(1);
      end
    end
  end
endmodule

// File: rtl/rx_err_queue.sv
module rx_err_queue #(
  parameter int DEPTH   = 16,
  parameter int DATA_W  = 8,
  parameter int FRAME_W = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [1:0]         trig_sel,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic               tick16,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [2:0]         in_flags,
  output logic               in_ready,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic [2:0]         head_flags,
  input  logic               lsr_rd,
  output logic               data_ready,
  output logic               trig_hit,
  output logic               overrun,
  output logic               err_any,
  output logic               timeout,
  output logic [CW-1:0]      count
);
  logic full, empty, push_ok, pop_ok, mask;
  logic [DATA_W-1:0] hd;
  rxq_pkg::rxq_tags_t ht, wt;
  logic [CW-1:0] level;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = in_valid && !full && !clr;
  assign pop_ok  = out_ready && !empty && !clr;
  assign wt      = rxq_pkg::rxq_tags_t'(in_flags);

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(clr),
    .wr_en(push_ok), .wr_data(in_data), .wr_tags(wt),
    .rd_en(pop_ok), .head_data(hd), .head_tags(ht), .fill(count)
  );

  rxq_errtrack #(.DEPTH(DEPTH)) u_err (
    .clk(clk), .rst_n(rst_n), .flush(clr),
    .wr_en(push_ok), .wr_bad(|in_flags),
    .rd_en(pop_ok), .rd_bad(|ht),
    .lsr_rd(lsr_rd), .empty(empty),
    .summary(err_any), .mask(mask)
  );

  rxq_idle_timer #(.FRAME_W(FRAME_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .flush(clr), .tick(tick16),
    .busy(!empty), .arrive(in_valid), .take(pop_ok),
    .frame_bits(frame_bits), .fired(timeout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        overrun <= 1'b0;
    else if (in_valid && full && !clr) overrun <= 1'b1;
    else if (lsr_rd)                   overrun <= 1'b0;
  end

  assign level      = CW'(rxq_pkg::sel_level(trig_sel, DEPTH));
  assign trig_hit   = (count >= level);
  assign in_ready   = !full;
  assign out_valid  = !empty;
  assign data_ready = !empty;
  assign out_data   = empty ? '0 : hd;
  assign head_flags = (empty || mask) ? 3'b000 : 3'(ht);
endmodule

// File: rtl/rx_err_queue_chk.sv
module rx_err_queue_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic [1:0]    trig_sel,
  input logic          in_valid,
  input logic          out_ready,
  input logic          lsr_rd,
  input logic [2:0]    head_flags,
  input logic          data_ready,
  input logic          trig_hit,
  input logic          overrun,
  input logic          err_any,
  input logic          timeout,
  input logic [CW-1:0] count
);
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_top_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_sel == 2'd3 && trig_hit) |-> count >= CW'(DEPTH - 2));

  p_ready_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(in_valid));

  p_overrun_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count == CW'(DEPTH) && !clr) |=> overrun);

  p_empty_tags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> head_flags == 3'b000);

  p_summary_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && !lsr_rd && !clr) |=> err_any);

  p_timeout_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> data_ready);

  p_pop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && data_ready && !clr) |=> !timeout);

  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !timeout && !err_any));

  p_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && !clr && count != '0 && count != CW'(DEPTH))
      |=> $stable(count));

  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !in_valid) |=> !data_ready);
endmodule

bind rx_err_queue rx_err_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .trig_sel(trig_sel),
  .in_valid(in_valid), .out_ready(out_ready), .lsr_rd(lsr_rd),
  .head_flags(head_flags), .data_ready(data_ready), .trig_hit(trig_hit),
  .overrun(overrun), .err_any(err_any), .timeout(timeout), .count(count)
);

// File: tb/rx_err_queue_test.sv
module rx_err_queue_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, tick16 = 1'b0, in_valid = 1'b0, out_ready = 1'b0, lsr_rd = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [3:0] frame_bits = 4'd2;
  logic [7:0] in_data = '0;
  logic [2:0] in_flags = '0;
  logic in_ready, out_valid, data_ready, trig_hit, overrun, err_any, timeout;
  logic [7:0] out_data;
  logic [2:0] head_flags;
  logic [4:0] count;

  int total = 0, bad = 0;

  // reference state
  logic [10:0] mq[$];
  bit m_mask, m_ovr, m_eflag, m_to;
  int m_errs, m_tmr;

  always #2.5 clk = ~clk;

  rx_err_queue uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .trig_sel(trig_sel),
    .frame_bits(frame_bits), .tick16(tick16), .in_valid(in_valid),
    .in_data(in_data), .in_flags(in_flags), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .head_flags(head_flags), .lsr_rd(lsr_rd), .data_ready(data_ready),
    .trig_hit(trig_hit), .overrun(overrun), .err_any(err_any),
    .timeout(timeout), .count(count)
  );

  function automatic int exp_level(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return DEPTH - 2;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit full, empty, pushok, popok, hbad;
    int nerrs;
    full   = (mq.size() == DEPTH);
    empty  = (mq.size() == 0);
    pushok = in_valid && !full && !clr;
    popok  = out_ready && !empty && !clr;
    hbad   = !empty && (mq[0][10:8] != 3'b000);
    nerrs  = clr ? 0 : m_errs + int'(pushok && in_flags != 0) - int'(popok && hbad);
    if (clr) m_eflag = 0;
    else if (pushok && in_flags != 0) m_eflag = 1;
    else if (lsr_rd && nerrs == 0) m_eflag = 0;
    m_errs = nerrs;
    if (popok || clr || empty) m_mask = 0; else if (lsr_rd) m_mask = 1;
    if (in_valid && full && !clr) m_ovr = 1; else if (lsr_rd) m_ovr = 0;
    if (clr || popok) begin m_tmr = 0; m_to = 0; end
    else if (m_to) ;
    else if (in_valid || empty) m_tmr = 0;
    else if (tick16) begin
      if (m_tmr == 64 * int'(frame_bits) - 1) begin m_to = 1; m_tmr = 0; end
      else m_tmr++;
    end
    if (clr) mq.delete();
    else begin
      if (popok) void'(mq.pop_front());
      if (pushok) mq.push_back({in_flags, in_data});
    end
  endtask

  task automatic compare();
    int n;
    n = mq.size();
    chk(count == 5'(n), "R1 count", count, n);
    chk(data_ready == (n != 0), "R3 data_ready", data_ready, n != 0);
    chk(trig_hit == (n >= exp_level(trig_sel)), "R2 trig_hit", trig_hit, n >= exp_level(trig_sel));
    chk(overrun == m_ovr, "R4 overrun", overrun, m_ovr);
    chk(err_any == m_eflag, "R6 err_any", err_any, m_eflag);
    chk(timeout == m_to, "R7/R8 timeout", timeout, m_to);
    if (n != 0) begin
      chk(out_data == mq[0][7:0], "R1 out_data", out_data, mq[0][7:0]);
      chk(head_flags == (m_mask ? 3'b000 : mq[0][10:8]), "R5 head_flags",
          head_flags, m_mask ? 0 : mq[0][10:8]);
    end else begin
      chk(head_flags == 3'b000, "R5 head_flags empty", head_flags, 0);
      chk(!out_valid, "R11 out_valid", out_valid, 0);
    end
  endtask

  task automatic cyc(input bit v, input logic [7:0] d, input logic [2:0] f,
                     input bit rd, input bit ls, input bit cl, input bit tk);
    in_valid = v; in_data = d; in_flags = f;
    out_ready = rd; lsr_rd = ls; clr = cl; tick16 = tk;
    @(posedge clk);
    model_step();
    #1;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 8'h00, 3'b000, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk(count == 0 && !data_ready && !overrun && !err_any && !timeout,
        "R3 reset state", count, 0);
    chk(in_ready && !out_valid, "R11 reset handshake", out_valid, 0);

    // R11: pop on empty
    cyc(0, 8'h00, 3'b000, 1, 0, 0, 1);
    chk(count == 0, "R11 pop empty", count, 0);

    // fill to full with tags on some entries, check thresholds, then overrun
    for (int i = 0; i < DEPTH; i++) begin
      trig_sel = 2'(i % 4);
      cyc(1, 8'(8'h40 + i), (i == 3) ? 3'b010 : 3'b000, 0, 0, 0, 0);
    end
    chk(!in_ready, "R1 full", in_ready, 0);
    cyc(1, 8'hEE, 3'b001, 0, 0, 0, 0);
    chk(overrun && count == DEPTH, "R4 overrun discard", count, DEPTH);
    // R9: flush keeps overrun
    cyc(0, 8'h00, 3'b000, 0, 0, 1, 0);
    chk(count == 0 && overrun, "R9 flush", overrun, 1);
    cyc(0, 8'h00, 3'b000, 0, 1, 0, 0);

    // R5 / R6: tag visibility and status-read mask
    cyc(1, 8'h11, 3'b100, 0, 0, 0, 0);
    cyc(1, 8'h22, 3'b000, 0, 0, 0, 0);
    chk(head_flags == 3'b100, "R5 break at head", head_flags, 4);
    cyc(0, 8'h00, 3'b000, 0, 1, 0, 0);
    chk(head_flags == 3'b000 && err_any, "R5 masked after status read", head_flags, 0);
    cyc(0, 8'h00, 3'b000, 1, 0, 0, 0);
    cyc(0, 8'h00, 3'b000, 0, 1, 0, 0);
    chk(!err_any, "R6 summary cleared", err_any, 0);

    // R10: simultaneous push and pop
    cyc(1, 8'h33, 3'b000, 1, 0, 0, 0);
    chk(count == 1, "R10 pair", count, 1);

    // R7 / R8: timeout with short frame, pending timeout ignores arrivals
    frame_bits = 4'd2;
    idle(130);
    chk(timeout, "R7 fired", timeout, 1);
    cyc(1, 8'h44, 3'b000, 0, 0, 0, 1);
    chk(timeout, "R8 arrival ignored while pending", timeout, 1);
    cyc(0, 8'h00, 3'b000, 1, 0, 0, 1);
    chk(!timeout, "R8 read clears", timeout, 0);
    frame_bits = 4'd10;
    idle(645);
    chk(timeout, "R7 ten-bit frame", timeout, 1);
    cyc(0, 8'h00, 3'b000, 0, 0, 1, 1);
    frame_bits = 4'd2;

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      bit quiet;
      quiet = ((i / 400) % 3) == 2;
      if ($urandom % 50 == 0) trig_sel = 2'($urandom);
      cyc(!quiet && ($urandom % 3 == 0), 8'($urandom),
          ($urandom % 4 == 0) ? 3'($urandom) : 3'b000,
          quiet ? ($urandom % 200 == 0) : ($urandom % 4 == 0),
          $urandom % 8 == 0, $urandom % 300 == 0, $urandom % 2 == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule